// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block produces the data-memory address for instructions that use indirect addressing. It holds a file of 16-bit auxiliary registers and a 3-bit pointer that chooses the current one. The current register drives the address output directly, so the address seen during an access is the value from before any change. When an operation is presented, the chosen register is post-modified at the next rising clock edge. The modification can be none, plus one, minus one, plus or minus the contents of register 0, or plus or minus register 0 with the carry running from the most significant bit toward the least significant bit. That last form walks a buffer in bit-reversed order, as an FFT needs.

In the same operation the pointer may be moved to another register. A select beyond the registers that exist is refused: the pointer keeps its value and an error pulse is raised. A separate load port writes a register directly. The number of registers and the presence of the bit-reversed modes are parameters, so a reduced build with five registers and no bit-reversed modes is a legal variant.

The block has no state machine. Its only sequential state is the register file and the pointer, and each rising edge commits one operation.

Top module: `arg_addr_gen`

## Requirements
- R1: After reset all registers and the pointer are 0, so `addr` is 0, `arp` is 0 and `sel_err` is 0.
- R2: With `ld_en` high, register `ld_sel` takes `ld_data` at the rising edge. When the same register is also being post-modified in that cycle, the loaded value wins.
- R3: `addr` always equals the register selected by `arp` (a register holding 1281 gives address 1281). With `op_valid` high, `op_mode` code 0 leaves the register unchanged, code 1 adds one and code 2 subtracts one, modulo 2^16, and code 7 leaves it unchanged.
- R4: `op_mode` code 3 adds register 0 to the current register and code 4 subtracts register 0 from it, modulo 2^16, using the value register 0 held before the edge.
- R5: `op_mode` code 5 adds and code 6 subtracts register 0 with carry or borrow passed from bit 15 toward bit 0. When the parameter `HAS_BR` is 0, codes 5 and 6 leave the register unchanged.
- R6: When `op_valid` and `nxt_valid` are both high and `nxt_ptr` is below `NUM_AR`, `arp` takes `nxt_ptr` at the edge, after the register update.
- R7: When `op_valid` and `nxt_valid` are both high and `nxt_ptr` is at or above `NUM_AR`, `arp` keeps its value and `sel_err` is high for the following cycle only. `arp` never reaches `NUM_AR` or above.
- R8: With `op_valid` low, no register is post-modified and `arp` does not change, whatever `op_mode`, `nxt_valid` or `nxt_ptr` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Commit one indirect access this cycle |
| op_mode | input | 3 | Post-modify code (see R3 to R5) |
| nxt_valid | input | 1 | Move the pointer with this access |
| nxt_ptr | input | 3 | New pointer value |
| ld_en | input | 1 | Direct register load |
| ld_sel | input | 3 | Register to load |
| ld_data | input | AW | Value to load |
| addr | output | AW | Current register, value before modification |
| arp | output | 3 | Current pointer |
| sel_err | output | 1 | Out-of-range select seen in previous cycle |

## Verification
`addr` is combinational on the state, so its pre-modify value is sampled one time unit after the inputs are applied, before the rising edge. The post-modified register, the new `arp` and the `sel_err` pulse are all due exactly one rising edge after the operation. The bench therefore samples them at the falling edge that follows, and it has already cleared the inputs by then, so no check picks up the next operation. A default instance and a reduced instance with five registers and no bit-reversed modes take the same stimulus, which lets random pointer values of 5 to 7 exercise the refusal path.

// File: rtl/arg_pkg.sv
package arg_pkg;

    typedef enum logic [2:0] {
        AM_HOLD  = 3'd0,
        AM_INC   = 3'd1,
        AM_DEC   = 3'd2,
        AM_ADD0  = 3'd3,
        AM_SUB0  = 3'd4,
        AM_BRADD = 3'd5,
        AM_BRSUB = 3'd6,
        AM_RSVD  = 3'd7
    } amode_e;

endpackage

// File: rtl/arg_update.sv
module arg_update
    import arg_pkg::*;
#(
    parameter int AW     = 16,
    parameter bit HAS_BR = 1'b1
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] ar0,
    input  logic [2:0]    mode,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0] cur_r;
    logic [AW-1:0] ar0_r;
    logic [AW-1:0] sum_r;
    logic [AW-1:0] dif_r;
    logic [AW-1:0] br_sum;
    logic [AW-1:0] br_dif;

    // mirror operands so an ordinary adder runs its carry from MSB to LSB
    for (genvar g = 0; g < AW; g++) begin : g_rev
        assign cur_r[g]  = cur[AW-1-g];
        assign ar0_r[g]  = ar0[AW-1-g];
        assign br_sum[g] = sum_r[AW-1-g];
        assign br_dif[g] = dif_r[AW-1-g];
    end

    assign sum_r = cur_r + ar0_r;
    assign dif_r = cur_r - ar0_r;

    always_comb begin
        nxt = cur;
        unique case (amode_e'(mode))
            AM_HOLD:  nxt = cur;
            AM_INC:   nxt = cur + AW'(1);
            AM_DEC:   nxt = cur - AW'(1);
            AM_ADD0:  nxt = cur + ar0;
            AM_SUB0:  nxt = cur - ar0;
            AM_BRADD: nxt = HAS_BR ? br_sum : cur;
            AM_BRSUB: nxt = HAS_BR ? br_dif : cur;
            AM_RSVD:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/arg_regfile.sv
module arg_regfile #(
    parameter int AW     = 16,
    parameter int NUM_AR = 8,
    parameter int PW     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_en,
    input  logic [PW-1:0]               upd_sel,
    input  logic [AW-1:0]               upd_data,
    input  logic                        ld_en,
    input  logic [PW-1:0]               ld_sel,
    input  logic [AW-1:0]               ld_data,
    output logic [NUM_AR-1:0][AW-1:0]   ar_q
);

    for (genvar g = 0; g < NUM_AR; g++) begin : g_ar
        logic [AW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (ld_en && ld_sel == PW'(g)) begin
                q <= ld_data;
            end else if (upd_en && upd_sel == PW'(g)) begin
                q <= upd_data;
            end
        end
        assign ar_q[g] = q;
    end

endmodule

// File: rtl/arg_ptr.sv
module arg_ptr #(
    parameter int NUM_AR = 8,
    parameter int PW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          nxt_valid,
    input  logic [PW-1:0] nxt_ptr,
    output logic [PW-1:0] arp,
    output logic          sel_err
);

    localparam logic [PW:0] LIM = (PW+1)'(NUM_AR);

    logic in_range;
    logic want;

    assign in_range = ({1'b0, nxt_ptr} < LIM);
    assign want     = op_valid && nxt_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arp     <= '0;
            sel_err <= 1'b0;
        end else begin
            sel_err <= want && !in_range;
            if (want && in_range) begin
                arp <= nxt_ptr;
            end
        end
    end

endmodule

// File: rtl/arg_addr_gen.sv
module arg_addr_gen #(
    parameter int AW     = 16,
    parameter int NUM_AR = 8,
    parameter bit HAS_BR = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_mode,
    input  logic          nxt_valid,
    input  logic [2:0]    nxt_ptr,
    input  logic          ld_en,
    input  logic [2:0]    ld_sel,
    input  logic [AW-1:0] ld_data,
    output logic [AW-1:0] addr,
    output logic [2:0]    arp,
    output logic          sel_err
);

    localparam int PW = 3;

    logic [NUM_AR-1:0][AW-1:0] ar_q;
    logic [AW-1:0]             cur;
    logic [AW-1:0]             upd_val;

    assign cur  = ar_q[arp];
    assign addr = cur;

    arg_update #(.AW(AW), .HAS_BR(HAS_BR)) u_upd (
        .cur  (cur),
        .ar0  (ar_q[0]),
        .mode (op_mode),
        .nxt  (upd_val)
    );

    arg_regfile #(.AW(AW), .NUM_AR(NUM_AR), .PW(PW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (op_valid),
        .upd_sel  (arp),
        .upd_data (upd_val),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_data  (ld_data),
        .ar_q     (ar_q)
    );

    arg_ptr #(.NUM_AR(NUM_AR), .PW(PW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .nxt_valid (nxt_valid),
        .nxt_ptr   (nxt_ptr),
        .arp       (arp),
        .sel_err   (sel_err)
    );

endmodule

// File: rtl/arg_checker.sv
module arg_checker #(
    parameter int AW     = 16,
    parameter int NUM_AR = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [2:0]    op_mode,
    input logic          nxt_valid,
    input logic [2:0]    nxt_ptr,
    input logic          ld_en,
    input logic [AW-1:0] addr,
    input logic [2:0]    arp,
    input logic          sel_err
);

    localparam logic [3:0] LIM = 4'(NUM_AR);

    p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_mode == 3'd1 && !nxt_valid && !ld_en
        |=> addr == $past(addr) + AW'(1));

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_mode == 3'd2 && !nxt_valid && !ld_en
        |=> addr == $past(addr) - AW'(1));

    p_ptr_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && nxt_valid && ({1'b0, nxt_ptr} < LIM)
        |=> arp == $past(nxt_ptr));

    p_bad_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && nxt_valid && ({1'b0, nxt_ptr} >= LIM)
        |=> sel_err && $stable(arp));

    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> $past(op_valid && nxt_valid));

    p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, arp} < LIM);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid && !ld_en |=> $stable(addr) && $stable(arp) && !sel_err);

endmodule

bind arg_addr_gen arg_checker #(.AW(AW), .NUM_AR(NUM_AR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_mode   (op_mode),
    .nxt_valid (nxt_valid),
    .nxt_ptr   (nxt_ptr),
    .ld_en     (ld_en),
    .addr      (addr),
    .arp       (arp),
    .sel_err   (sel_err)
);

// File: tb/sim_arg_addr_gen.sv
`timescale 1ns/1ps
module sim_arg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, nxt_valid, ld_en;
    logic [2:0]  op_mode, nxt_ptr, ld_sel;
    logic [15:0] ld_data;
    logic [15:0] addr0, addr1;
    logic [2:0]  arp0, arp1;
    logic        err0, err1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] m_ar [2][8];
    int          m_arp [2];
    bit          m_err [2];
    int          lim   [2] = '{8, 5};
    bit          hbr   [2] = '{1'b1, 1'b0};

    always #2.5 clk = ~clk;

    arg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .nxt_valid(nxt_valid), .nxt_ptr(nxt_ptr), .ld_en(ld_en),
        .ld_sel(ld_sel), .ld_data(ld_data),
        .addr(addr0), .arp(arp0), .sel_err(err0)
    );

    arg_addr_gen #(.NUM_AR(5), .HAS_BR(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .nxt_valid(nxt_valid), .nxt_ptr(nxt_ptr), .ld_en(ld_en),
        .ld_sel(ld_sel), .ld_data(ld_data),
        .addr(addr1), .arp(arp1), .sel_err(err1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // carry walks from bit 15 down to bit 0
    function automatic logic [15:0] rc_arith(input logic [15:0] a, input logic [15:0] b, input bit sub);
        logic [15:0] r;
        logic [15:0] bb;
        logic        c;
        bb = sub ? ~b : b;
        c  = sub;
        for (int i = 15; i >= 0; i--) begin
            r[i] = a[i] ^ bb[i] ^ c;
            c    = (a[i] & bb[i]) | (c & (a[i] ^ bb[i]));
        end
        return r;
    endfunction

    function automatic logic [15:0] next_val(input logic [15:0] cur, input logic [15:0] ar0,
                                             input logic [2:0] md, input bit hb);
        case (md)
            3'd1: return cur + 16'd1;
            3'd2: return cur - 16'd1;
            3'd3: return cur + ar0;
            3'd4: return cur - ar0;
            3'd5: return hb ? rc_arith(cur, ar0, 1'b0) : cur;
            3'd6: return hb ? rc_arith(cur, ar0, 1'b1) : cur;
            default: return cur;
        endcase
    endfunction

    function automatic string mode_tag(input logic [2:0] md);
        if (md == 3'd3 || md == 3'd4) return "R4";
        if (md == 3'd5 || md == 3'd6) return "R5";
        return "R3";
    endfunction

    task automatic run_op(input bit v, input logic [2:0] md, input bit nv, input logic [2:0] np,
                          input bit le, input logic [2:0] ls, input logic [15:0] ld);
        op_valid = v; op_mode = md; nxt_valid = nv; nxt_ptr = np;
        ld_en = le; ld_sel = ls; ld_data = ld;
        #1;
        for (int d = 0; d < 2; d++) begin
            logic [15:0] a_d;
            a_d = (d == 0) ? addr0 : addr1;
            check("R3 pre-modify address", 32'(a_d), 32'(m_ar[d][m_arp[d]]));
        end
        @(posedge clk);
        for (int d = 0; d < 2; d++) begin
            logic [15:0] nv_d;
            nv_d = next_val(m_ar[d][m_arp[d]], m_ar[d][0], md, hbr[d]);
            if (v) m_ar[d][m_arp[d]] = nv_d;
            if (le && int'(ls) < lim[d]) m_ar[d][ls] = ld;
            m_err[d] = v && nv && int'(np) >= lim[d];
            if (v && nv && int'(np) < lim[d]) m_arp[d] = int'(np);
        end
        @(negedge clk);
        op_valid = 1'b0; nxt_valid = 1'b0; ld_en = 1'b0;
        for (int d = 0; d < 2; d++) begin
            logic [15:0] a_d;
            logic [2:0]  p_d;
            logic        e_d;
            a_d = (d == 0) ? addr0 : addr1;
            p_d = (d == 0) ? arp0  : arp1;
            e_d = (d == 0) ? err0  : err1;
            check(!v ? "R8 idle pointer" : "R6 pointer", 32'(p_d), 32'(m_arp[d]));
            check("R7 select error", 32'(e_d), 32'(m_err[d]));
            check(le ? "R2 load/update" : (!v ? "R8 idle register" : mode_tag(md)),
                  32'(a_d), 32'(m_ar[d][m_arp[d]]));
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int fft_exp [8] = '{0, 8, 4, 12, 2, 10, 6, 14};
        void'($urandom(32'd20517));
        rst_n = 1'b0; op_valid = 1'b0; op_mode = 3'd0; nxt_valid = 1'b0;
        nxt_ptr = 3'd0; ld_en = 1'b0; ld_sel = 3'd0; ld_data = 16'd0;
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 8; i++) m_ar[d][i] = 16'd0;
            m_arp[d] = 0; m_err[d] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 addr0", 32'(addr0), 32'd0);
        check("R1 arp0", 32'(arp0), 32'd0);
        check("R1 err0", 32'(err0), 32'd0);
        check("R1 addr1", 32'(addr1), 32'd0);

        // R3 a register holding 1281 gives address 1281
        run_op(1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd3, 16'd1281);
        run_op(1'b1, 3'd0, 1'b1, 3'd3, 1'b0, 3'd0, 16'd0);
        check("R3 address 1281", 32'(addr0), 32'd1281);

        // R5 bit-reversed walk of a 16-point buffer
        run_op(1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd0, 16'd8);
        run_op(1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd1, 16'd0);
        run_op(1'b1, 3'd0, 1'b1, 3'd1, 1'b0, 3'd0, 16'd0);
        for (int k = 0; k < 8; k++) begin
            check("R5 bit-reversed sequence", 32'(addr0), 32'(fft_exp[k]));
            run_op(1'b1, 3'd5, 1'b0, 3'd0, 1'b0, 3'd0, 16'd0);
        end
        check("R5 no bit-reverse when HAS_BR=0", 32'(addr1), 32'd0);
        run_op(1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 3'd0, 16'd0);

        // R3 wrap on increment
        run_op(1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd1, 16'hFFFF);
        run_op(1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 3'd0, 16'd0);
        check("R3 increment wraps", 32'(addr0), 32'd0);

        // R4 subtract below zero wraps
        run_op(1'b1, 3'd4, 1'b0, 3'd0, 1'b0, 3'd0, 16'd0);
        check("R4 subtract wraps", 32'(addr0), 32'hFFF8);

        // R2 load wins over post-modify on the same register
        run_op(1'b1, 3'd1, 1'b0, 3'd0, 1'b1, 3'd1, 16'h0055);
        check("R2 load priority", 32'(addr0), 32'h0055);

        // R7 out-of-range select on the reduced instance
        run_op(1'b1, 3'd0, 1'b1, 3'd6, 1'b0, 3'd0, 16'd0);
        check("R7 reduced pointer kept", 32'(arp1), 32'd1);
        check("R7 reduced error pulse", 32'(err1), 32'd1);
        check("R6 full instance moves", 32'(arp0), 32'd6);
        run_op(1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 16'd0);
        check("R7 error lasts one cycle", 32'(err1), 32'd0);

        // R8 pointer request without an operation is ignored
        run_op(1'b0, 3'd1, 1'b1, 3'd2, 1'b0, 3'd0, 16'd0);
        check("R8 pointer unchanged", 32'(arp0), 32'd6);

        // random mix
        for (int n = 0; n < 600; n++) begin
            bit          rv, rn, rl;
            logic [2:0]  rm, rp, rs;
            logic [15:0] rd;
            rv = ($urandom % 4) != 0;
            rn = ($urandom % 3) == 0;
            rl = ($urandom % 5) == 0;
            rm = 3'($urandom);
            rp = 3'($urandom);
            rs = 3'($urandom);
            rd = 16'($urandom);
            run_op(rv, rm, rn, rp, rl, rs, rd);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule